// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block produces the serial clock waveform for an I2C byte engine. It keeps SCL released while idle. On a request from the engine it times a START hold interval, then drives SCL low and raises alternating low and high phases. It stops driving when the engine withdraws its request at the end of a high phase. Each phase length is a 9-bit count of prescaled ticks. The prescaler divides the input clock by a clocks-per-count factor. For each count, the lower eight bits arrive on one port and the ninth bit arrives on a separate port, because it is held in a different control register.

The low phase is timed from the cycle in which the block starts driving SCL low. The high phase is timed only after the SCL line, as sensed through a two-stage synchronizer, has really gone high. Rise time is therefore not counted in the high period. A slave that holds SCL low extends the clock for as long as it holds it. The high count also sets how long SCL stays high after the engine asks for a START, that is, the interval from SDA falling to SCL falling.

The engine receives two single-cycle strobes. One marks the start of each driven-low phase, where data may be shifted. The other marks the start of each counted high phase, where data may be sampled.

Top module: `scl_phase_timer`

## Requirements
- R1: After reset, and while idle, `scl_drive_low`, `scl_rise_stb` and `scl_fall_stb` are all 0.
- R2: When `phase_req` is seen high in idle with `enable` high, SCL stays released for H*P clock cycles after the next clock edge, then is driven low. H is the effective high count and P is the effective prescale.
- R3: Each driven-low phase lasts exactly L*P clock cycles, where L is the effective low count.
- R4: The high phase counts H*P cycles only after the synchronized SCL input is high. With no stretching, SCL is released for H*P+3 cycles between two low phases.
- R5: While an external device holds `scl_in` low after release, no rise strobe occurs and SCL is not driven. The rise strobe appears in the third cycle after `scl_in` returns high.
- R6: Each count is 9 bits wide. `low_cnt_b8` and `high_cnt_b8` supply bit 8, and `low_cnt` and `high_cnt` supply bits 7..0.
- R7: A count of 0 acts as 1, and a prescale of 0 acts as 1.
- R8: `scl_fall_stb` is high for exactly the first cycle of each driven-low phase. `scl_rise_stb` is high for exactly the first cycle of each counted high phase. The two never coincide.
- R9: If `phase_req` is low when a high phase expires, the block returns to idle and leaves SCL released.
- R10: When `enable` is low, SCL is released from the next cycle and `phase_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces idle |
| prescale | input | PRE_W | Input clocks per count tick (0 acts as 1) |
| low_cnt | input | 8 | Low-phase count bits 7..0 |
| low_cnt_b8 | input | 1 | Low-phase count bit 8 |
| high_cnt | input | 8 | High-phase and START-hold count bits 7..0 |
| high_cnt_b8 | input | 1 | High-phase count bit 8 |
| phase_req | input | 1 | Engine request to start or continue clocking |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| scl_rise_stb | output | 1 | One-cycle strobe at the start of the counted high phase |
| scl_fall_stb | output | 1 | One-cycle strobe at the start of the driven-low phase |

## Verification
All outputs are registered. A request seen at a clock edge moves the block into the START hold state at that edge, and the drive output rises H*P cycles later. After release, the sensed high takes two synchronizer stages plus one state register to act on, so the rise strobe is due in the third cycle after the line goes high. The bench drives inputs on falling edges and samples outputs on falling edges. It measures every phase as a run of consecutive falling-edge samples and compares that run with the expected length: H*P+1 for the hold (this includes the sample at which the request is driven), L*P for low, and H*P+3 for released. It checks the strobes at the exact sample index where they are due.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
    localparam int CNT_W = 9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_WAIT_HI,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   drive;
        logic   rise;
        logic   fall;
        logic   lo_seen;
    } fsm_regs_t;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int CNT_W = 9,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [PRE_W-1:0] prescale,
    output logic             expire
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;
    logic [PRE_W-1:0] pre_top;
    logic [CNT_W-1:0] cnt_top;

    always_comb begin
        pre_top = (prescale == '0) ? '0 : prescale - 1'b1;
        cnt_top = (load_cnt == '0) ? '0 : load_cnt - 1'b1;
        r_d = r_q;
        if (load) begin
            r_d.pre = pre_top;
            r_d.cnt = cnt_top;
        end else if (r_q.pre == '0) begin
            r_d.pre = pre_top;
            if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
        end else begin
            r_d.pre = r_q.pre - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expire = (r_q.pre == '0) && (r_q.cnt == '0);

    AST_CNT_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(r_q.cnt) != '0) |-> (r_q.cnt <= $past(r_q.cnt))) // R3
        else $error("count rose without a load");
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_timer_pkg::*;
#(
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    input  logic [7:0]       low_cnt,
    input  logic             low_cnt_b8,
    input  logic [7:0]       high_cnt,
    input  logic             high_cnt_b8,
    input  logic             phase_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb
);
    fsm_regs_t        s_d, s_q;
    logic             scl_s;
    logic             expire;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] lo_full, hi_full;

    assign lo_full = {low_cnt_b8, low_cnt};
    assign hi_full = {high_cnt_b8, high_cnt};

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .dout  (scl_s)
    );

    scl_phase_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_cnt (load_val),
        .prescale (prescale),
        .expire   (expire)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rise = 1'b0;
        s_d.fall = 1'b0;
        load     = 1'b0;
        load_val = hi_full;
        unique case (s_q.phase)
            PH_IDLE: if (phase_req) begin
                s_d.phase = PH_HOLD;
                load      = 1'b1;
            end
            PH_HOLD: if (expire) begin
                s_d.phase = PH_LOW;
                load      = 1'b1;
                load_val  = lo_full;
                s_d.fall  = 1'b1;
            end
            PH_LOW: if (expire) s_d.phase = PH_WAIT_HI;
            PH_WAIT_HI: if (scl_s && s_q.lo_seen) begin
                s_d.phase = PH_HIGH;
                load      = 1'b1;
                s_d.rise  = 1'b1;
            end
            PH_HIGH: if (expire) begin
                if (phase_req) begin
                    s_d.phase = PH_LOW;
                    load      = 1'b1;
                    load_val  = lo_full;
                    s_d.fall  = 1'b1;
                end else begin
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
        if (!enable) begin
            s_d.phase = PH_IDLE;
            s_d.rise  = 1'b0;
            s_d.fall  = 1'b0;
            load      = 1'b0;
        end
        s_d.drive   = (s_d.phase == PH_LOW);
        s_d.lo_seen = s_d.fall ? 1'b0 : (s_q.lo_seen | ~scl_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, drive: 1'b0, rise: 1'b0, fall: 1'b0, lo_seen: 1'b0};
        else        s_q <= s_d;
    end

    assign scl_drive_low = s_q.drive;
    assign scl_rise_stb  = s_q.rise;
    assign scl_fall_stb  = s_q.fall;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise_stb && scl_fall_stb)) // R8
        else $error("rise and fall strobes together");
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |=> !scl_fall_stb) // R8
        else $error("fall strobe longer than one cycle");
    AST_FALL_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |-> scl_drive_low) // R8
        else $error("fall strobe without drive");
    AST_RISE_SENSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_rise_stb) |-> $past(scl_s)) // R5
        else $error("rise strobe before SCL sensed high");
    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low) // R10
        else $error("SCL driven while disabled");
endmodule

// File: tb/scl_phase_timer_tb.sv
`timescale 1ns/1ps
module scl_phase_timer_tb;
    localparam int PRE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [PRE_W-1:0] prescale = '0;
    logic [7:0] low_cnt = '0, high_cnt = '0;
    logic low_cnt_b8 = 1'b0, high_cnt_b8 = 1'b0;
    logic phase_req = 1'b0;
    logic stretch = 1'b0;
    logic scl_in;
    logic scl_drive_low, scl_rise_stb, scl_fall_stb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign scl_in = ~(scl_drive_low | stretch);

    scl_phase_timer #(.PRE_W(PRE_W), .SYNC_STAGES(2)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .prescale      (prescale),
        .low_cnt       (low_cnt),
        .low_cnt_b8    (low_cnt_b8),
        .high_cnt      (high_cnt),
        .high_cnt_b8   (high_cnt_b8),
        .phase_req     (phase_req),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .scl_rise_stb  (scl_rise_stb),
        .scl_fall_stb  (scl_fall_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Run length of the present drive level, counted in falling-edge samples
    task automatic run_len(input logic val, output int n, output int rise_at, output int rises);
        n = 1; rise_at = 0; rises = 0;
        if (scl_rise_stb) begin rises++; rise_at = 1; end
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (scl_drive_low != val) break;
            n++;
            if (scl_rise_stb) begin rises++; rise_at = n; end
        end
    endtask

    task automatic set_cfg(input int lo9, input int hi9, input int pre);
        low_cnt     = lo9[7:0];
        low_cnt_b8  = lo9[8];
        high_cnt    = hi9[7:0];
        high_cnt_b8 = hi9[8];
        prescale    = pre[PRE_W-1:0];
    endtask

    // Full clocking sequence: hold, two lows, gap, then return to idle
    task automatic t_timing(input string name, input int lo9, input int hi9, input int pre);
        int n, ra, rc, lp, hp, p, fcount;
        p  = (pre == 0) ? 1 : pre;
        lp = ((lo9 == 0) ? 1 : lo9) * p;
        hp = ((hi9 == 0) ? 1 : hi9) * p;
        @(negedge clk);
        set_cfg(lo9, hi9, pre);
        enable = 1'b1;
        phase_req = 1'b1;
        run_len(1'b0, n, ra, rc);
        check(n == hp + 1, {"R2 start hold ", name}, n, hp + 1);
        check(scl_fall_stb == 1'b1, {"R8 fall strobe at first low ", name}, scl_fall_stb, 1);
        run_len(1'b1, n, ra, rc);
        check(n == lp, {"R3 low width ", name}, n, lp);
        run_len(1'b0, n, ra, rc);
        check(n == hp + 3, {"R4 released width ", name}, n, hp + 3);
        check(ra == 4 && rc == 1, {"R8 rise strobe position ", name}, ra * 10 + rc, 41);
        phase_req = 1'b0;
        run_len(1'b1, n, ra, rc);
        check(n == lp, {"R3 second low width ", name}, n, lp);
        fcount = 0;
        for (int i = 0; i < hp + 30; i++) begin
            if (scl_drive_low || scl_fall_stb) fcount++;
            @(negedge clk);
        end
        check(fcount == 0, {"R9 idle after last high ", name}, fcount, 0);
    endtask

    task automatic t_reset();
        check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R1 reset outputs",
              {scl_drive_low, scl_rise_stb, scl_fall_stb}, 0);
        phase_req = 1'b1;
        enable    = 1'b0;
        for (int i = 0; i < 10; i++) @(negedge clk);
        check(!scl_drive_low, "R10 request ignored when disabled", scl_drive_low, 0);
        phase_req = 1'b0;
    endtask

    task automatic t_stretch();
        int n, ra, rc, k, bad;
        @(negedge clk);
        set_cfg(6, 5, 2);
        enable = 1'b1;
        phase_req = 1'b1;
        run_len(1'b0, n, ra, rc);
        stretch = 1'b1;
        run_len(1'b1, n, ra, rc);
        check(n == 12, "R3 low width under stretch", n, 12);
        bad = 0;
        for (int i = 0; i < 15; i++) begin
            if (scl_drive_low || scl_rise_stb) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R5 no rise while held low", bad, 0);
        stretch = 1'b0;
        k = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            k++;
            if (scl_rise_stb) break;
        end
        check(k == 3, "R5 rise strobe after release", k, 3);
        k = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            k++;
            if (scl_drive_low) break;
        end
        check(k == 10, "R4 high counted after sensed rise", k, 10);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R10 release one cycle after disable", scl_drive_low, 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (scl_drive_low) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R10 stays released while disabled", bad, 0);
        phase_req = 1'b0;
        enable = 1'b1;
        for (int i = 0; i < 5; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing("basic", 5, 4, 1);
        t_timing("prescaled", 5, 4, 3);
        t_timing("R6 bit8 low", 258, 3, 1);
        t_timing("R6 bit8 high", 4, 300, 1);
        t_timing("R7 zeros", 0, 0, 0);
        t_timing("standard ref", 500, 430, 2);
        t_timing("fast ref", 160, 90, 2);
        t_stretch();
        finish_run();
    end
endmodule